// File: doc/BRIEF.md
# Display frame buffer address generator

This block produces the byte addresses a display refresh DMA engine uses to read pixel data, one 32-bit word per fetch, from a frame buffer in memory. The upper nibble of every address comes from a small base register, and the offset within that region always starts at zero. Each acknowledged fetch moves the offset on by one word. When the last word of the programmed buffer size has been fetched, the offset goes back to zero and a new frame begins.

Software sets the line length in 16-pixel units, the pixel depth and the buffer size in 128-byte units. The block reads these three values only at the start of a frame, so a frame in progress always runs with one consistent set. The base nibble may be written only while the engine is idle. A write made while the engine runs is dropped and sets a sticky error flag. Alongside each address the block flags the first word of a frame and the last word of each display line.

Top module: `fb_addr_gen`

## Requirements
- R1: After reset the base is 0xC, no fetch is requested, and the start-of-frame, line-end and error outputs are low.
- R2: The fetch address is the base nibble in bits 31:28, zeros in bits 27:17 and the frame offset in bits 16:0. When en_i is sampled high while idle, fetch_req_o rises on the next cycle with offset 0.
- R3: The offset grows by 4 on every cycle where fetch_req_o and fetch_ack_i are both high. It holds when no acknowledge is given. An acknowledge given while fetch_req_o is low has no effect.
- R4: The buffer size code S (10 bits) gives a last offset of S*128-4, and code 0 stands for 131072 bytes. An acknowledge at the last offset returns the offset to 0.
- R5: sof_o is high for exactly one cycle, together with the first request of every frame: the first after enable, and each one after a wrap.
- R6: line_end_o is high while the current request is the last word of a display line. A line holds L*M words, where L is the line length in 16-pixel units and M is 1, 2, 4 or 4 for depth codes 0, 1, 2 and 3 (2, 4, 8 and 8 bits per pixel). Line counting restarts at each frame start.
- R7: A line length code below 2 is treated as 2, and one above 64 is treated as 64, giving 32 to 1024 pixels.
- R8: The line length, depth and size inputs are sampled only when the engine is idle or on the acknowledge that wraps a frame. Changes during a frame have no effect until the next frame.
- R9: A base write while en_i or fetch_req_o is high leaves the base unchanged and sets base_err_o. An accepted write loads the base and clears base_err_o.
- R10: When en_i is sampled low, fetch_req_o is low on the next cycle and the offset returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Engine enable |
| base_we_i | input | 1 | Base nibble write strobe |
| base_wdata_i | input | 4 | Base nibble write data |
| line_len_i | input | 7 | Line length in 16-pixel units |
| depth_i | input | 2 | Pixel depth code |
| buf_size_i | input | 10 | Buffer size in 128-byte units, 0 means 128 KB |
| fetch_ack_i | input | 1 | Fetch accepted by memory side |
| fetch_req_o | output | 1 | Fetch request |
| fetch_addr_o | output | 32 | Byte address of the word to fetch |
| sof_o | output | 1 | First word of a frame |
| line_end_o | output | 1 | Last word of a display line |
| base_o | output | 4 | Current base nibble |
| base_err_o | output | 1 | Sticky blocked-write flag |

## Verification
A wrong offset shows up in fetch_addr_o on the very next request after the faulty acknowledge. A wrong wrap point or a wrongly latched size shows up at the end of the frame: sof_o comes early or late, and the address runs past or short of the expected last word. A miscounted line length or depth shows up as line_end_o on the wrong word within the first line of a frame. A faulty blocking of base writes shows up in base_o and base_err_o one cycle after the write.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int unsigned FB_ADDR_W  = 32;
  localparam int unsigned FB_BASE_W  = 4;
  localparam int unsigned FB_SIZE_W  = 10;
  localparam int unsigned FB_UNIT_LG = 7;   // 128-byte size unit
  localparam int unsigned FB_WORD_LG = 2;   // 4-byte fetch
  localparam int unsigned FB_LEN_W   = 7;
  localparam int unsigned FB_LEN_MIN = 2;
  localparam int unsigned FB_LEN_MAX = 64;
  localparam logic [3:0]  FB_BASE_RST = 4'hC;

  typedef enum logic [1:0] {
    DEPTH_2 = 2'd0,
    DEPTH_4 = 2'd1,
    DEPTH_8 = 2'd2,
    DEPTH_X = 2'd3
  } depth_e;
endpackage

// File: rtl/fb_cfg_latch.sv
module fb_cfg_latch
  import fb_pkg::*;
#(
  parameter int unsigned BASE_W  = FB_BASE_W,
  parameter int unsigned SIZE_W  = FB_SIZE_W,
  parameter int unsigned UNIT_LG = FB_UNIT_LG,
  parameter int unsigned WORD_LG = FB_WORD_LG,
  parameter int unsigned LEN_W   = FB_LEN_W,
  parameter int unsigned LEN_MIN = FB_LEN_MIN,
  parameter int unsigned LEN_MAX = FB_LEN_MAX,
  parameter logic [BASE_W-1:0] BASE_RST = FB_BASE_RST,
  localparam int unsigned OFF_W = SIZE_W + UNIT_LG,
  localparam int unsigned LW_W  = LEN_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              active_i,
  input  logic              load_i,
  input  logic              base_we_i,
  input  logic [BASE_W-1:0] base_wdata_i,
  input  logic [LEN_W-1:0]  line_len_i,
  input  depth_e            depth_i,
  input  logic [SIZE_W-1:0] buf_size_i,
  output logic [BASE_W-1:0] base_o,
  output logic              base_err_o,
  output logic [OFF_W-1:0]  end_off_o,
  output logic [LW_W-1:0]   line_words_o
);
  localparam logic [OFF_W-1:0] STEP    = OFF_W'(1) << WORD_LG;
  localparam logic [OFF_W-1:0] FULL_END = {OFF_W{1'b1}} - (STEP - OFF_W'(1));

  logic             blocked;
  logic [LEN_W-1:0] len_clamped;
  logic [1:0]       depth_sh;
  logic [OFF_W-1:0] end_off_d;
  logic [LW_W-1:0]  line_words_d;

  assign blocked = en_i | active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o     <= BASE_RST;
      base_err_o <= 1'b0;
    end else if (base_we_i) begin
      if (blocked) begin
        base_err_o <= 1'b1;
      end else begin
        base_o     <= base_wdata_i;
        base_err_o <= 1'b0;
      end
    end
  end

  always_comb begin
    if (line_len_i < LEN_W'(LEN_MIN))      len_clamped = LEN_W'(LEN_MIN);
    else if (line_len_i > LEN_W'(LEN_MAX)) len_clamped = LEN_W'(LEN_MAX);
    else                                   len_clamped = line_len_i;
  end

  always_comb begin
    unique case (depth_i)
      DEPTH_2: depth_sh = 2'd0;
      DEPTH_4: depth_sh = 2'd1;
      default: depth_sh = 2'd2;
    endcase
  end

  assign line_words_d = {2'b00, len_clamped} << depth_sh;

  always_comb begin
    if (buf_size_i == '0) end_off_d = FULL_END;
    else                  end_off_d = {buf_size_i, {UNIT_LG{1'b0}}} - STEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      end_off_o    <= FULL_END;
      line_words_o <= LW_W'(LEN_MIN);
    end else if (load_i) begin
      end_off_o    <= end_off_d;
      line_words_o <= line_words_d;
    end
  end

  p_base_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_we_i && blocked) |=> ($stable(base_o) && base_err_o));

  p_base_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_we_i && !blocked) |=> (base_o == $past(base_wdata_i) && !base_err_o));

  p_len_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_words_o >= LW_W'(LEN_MIN)) && (line_words_o <= (LW_W'(LEN_MAX) << 2)));

  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(end_off_o) && $stable(line_words_o)));
endmodule

// File: rtl/fb_offset_ctr.sv
module fb_offset_ctr #(
  parameter int unsigned OFF_W   = 17,
  parameter int unsigned LW_W    = 9,
  parameter int unsigned WORD_LG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ack_i,
  input  logic [OFF_W-1:0] end_off_i,
  input  logic [LW_W-1:0]  line_words_i,
  output logic             active_o,
  output logic [OFF_W-1:0] off_o,
  output logic             line_last_o,
  output logic             sof_o,
  output logic             load_o
);
  localparam logic [OFF_W-1:0] STEP = OFF_W'(1) << WORD_LG;

  logic            accept;
  logic            frame_last;
  logic            wrap;
  logic [LW_W-1:0] lcnt_q;

  assign accept      = active_o & ack_i;
  assign frame_last  = (off_o == end_off_i);
  assign line_last_o = active_o & (lcnt_q == line_words_i - LW_W'(1));
  assign wrap        = accept & frame_last;
  assign load_o      = ~active_o | wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      off_o    <= '0;
      lcnt_q   <= '0;
      sof_o    <= 1'b0;
    end else if (!en_i) begin
      active_o <= 1'b0;
      off_o    <= '0;
      lcnt_q   <= '0;
      sof_o    <= 1'b0;
    end else begin
      active_o <= 1'b1;
      sof_o    <= ~active_o | wrap;
      if (accept) begin
        off_o  <= frame_last ? '0 : off_o + STEP;
        lcnt_q <= (frame_last || line_last_o) ? '0 : lcnt_q + LW_W'(1);
      end
    end
  end

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && accept && !frame_last) |=> (off_o == $past(off_o) + STEP));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !accept) |=> $stable(off_o));

  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wrap) |=> (off_o == '0 && sof_o));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!active_o && off_o == '0 && !sof_o));

  p_line_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (lcnt_q < line_words_i));
endmodule

// File: rtl/fb_addr_gen.sv
module fb_addr_gen
  import fb_pkg::*;
#(
  parameter int unsigned ADDR_W  = FB_ADDR_W,
  parameter int unsigned BASE_W  = FB_BASE_W,
  parameter int unsigned SIZE_W  = FB_SIZE_W,
  parameter int unsigned UNIT_LG = FB_UNIT_LG,
  parameter int unsigned WORD_LG = FB_WORD_LG,
  parameter int unsigned LEN_W   = FB_LEN_W,
  parameter int unsigned LEN_MIN = FB_LEN_MIN,
  parameter int unsigned LEN_MAX = FB_LEN_MAX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              base_we_i,
  input  logic [BASE_W-1:0] base_wdata_i,
  input  logic [LEN_W-1:0]  line_len_i,
  input  logic [1:0]        depth_i,
  input  logic [SIZE_W-1:0] buf_size_i,
  input  logic              fetch_ack_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              sof_o,
  output logic              line_end_o,
  output logic [BASE_W-1:0] base_o,
  output logic              base_err_o
);
  localparam int unsigned OFF_W = SIZE_W + UNIT_LG;
  localparam int unsigned LW_W  = LEN_W + 2;
  localparam int unsigned PAD_W = ADDR_W - BASE_W - OFF_W;

  logic             active;
  logic             load;
  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] end_off;
  logic [LW_W-1:0]  line_words;

  fb_cfg_latch #(
    .BASE_W  (BASE_W),
    .SIZE_W  (SIZE_W),
    .UNIT_LG (UNIT_LG),
    .WORD_LG (WORD_LG),
    .LEN_W   (LEN_W),
    .LEN_MIN (LEN_MIN),
    .LEN_MAX (LEN_MAX)
  ) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .active_i     (active),
    .load_i       (load),
    .base_we_i    (base_we_i),
    .base_wdata_i (base_wdata_i),
    .line_len_i   (line_len_i),
    .depth_i      (depth_e'(depth_i)),
    .buf_size_i   (buf_size_i),
    .base_o       (base_o),
    .base_err_o   (base_err_o),
    .end_off_o    (end_off),
    .line_words_o (line_words)
  );

  fb_offset_ctr #(
    .OFF_W   (OFF_W),
    .LW_W    (LW_W),
    .WORD_LG (WORD_LG)
  ) u_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .ack_i        (fetch_ack_i),
    .end_off_i    (end_off),
    .line_words_i (line_words),
    .active_o     (active),
    .off_o        (off),
    .line_last_o  (line_end_o),
    .sof_o        (sof_o),
    .load_o       (load)
  );

  assign fetch_req_o  = active;
  assign fetch_addr_o = {base_o, {PAD_W{1'b0}}, off};

  p_sof_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> (fetch_req_o && off == '0));

  p_sof_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> !sof_o);

  p_word_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_addr_o[WORD_LG-1:0] == '0);

  p_base_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && $past(fetch_req_o)) |-> $stable(base_o));
endmodule

// File: tb/tb_fb_addr_gen.sv
module tb_fb_addr_gen;
  localparam int unsigned CYC    = 8;
  localparam int unsigned NCYCLE = 40000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        base_we_i = 1'b0;
  logic [3:0]  base_wdata_i = '0;
  logic [6:0]  line_len_i = '0;
  logic [1:0]  depth_i = '0;
  logic [9:0]  buf_size_i = '0;
  logic        fetch_ack_i = 1'b0;
  logic        fetch_req_o;
  logic [31:0] fetch_addr_o;
  logic        sof_o;
  logic        line_end_o;
  logic [3:0]  base_o;
  logic        base_err_o;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  // reference state
  bit          m_act, m_sof, m_err;
  logic [16:0] m_off, m_end;
  logic [8:0]  m_lcnt, m_lw;
  logic [3:0]  m_base;

  always #(CYC/2) clk_i = ~clk_i;

  fb_addr_gen dut (
    .clk_i, .rst_ni, .en_i, .base_we_i, .base_wdata_i, .line_len_i,
    .depth_i, .buf_size_i, .fetch_ack_i, .fetch_req_o, .fetch_addr_o,
    .sof_o, .line_end_o, .base_o, .base_err_o
  );

  function automatic logic [16:0] f_end(input logic [9:0] s);
    if (s == 0) return 17'h1FFFC;
    return 17'({s, 7'b0}) - 17'd4;
  endfunction

  function automatic logic [8:0] f_lw(input logic [6:0] l, input logic [1:0] d);
    int unsigned c, m;
    c = (l < 2) ? 2 : (l > 64) ? 64 : l;
    m = (d == 0) ? 1 : (d == 1) ? 2 : 4;
    return 9'(c * m);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    logic [31:0] ea;
    ea = {m_base, 11'b0, m_off};
    chk(fetch_req_o == m_act, "R2/R10 req", 32'(fetch_req_o), 32'(m_act));
    if (m_act)
      chk(fetch_addr_o == ea, "R2/R3/R4/R8 addr", fetch_addr_o, ea);
    chk(sof_o == m_sof, "R5 sof", 32'(sof_o), 32'(m_sof));
    chk(line_end_o == (m_act && m_lcnt == m_lw - 1), "R6/R7/R8 line_end",
        32'(line_end_o), 32'(m_act && m_lcnt == m_lw - 1));
    chk(base_o == m_base, "R9 base", 32'(base_o), 32'(m_base));
    chk(base_err_o == m_err, "R9 err", 32'(base_err_o), 32'(m_err));
  endtask

  task automatic step_model();
    bit acc, fl, ll, ld;
    acc = m_act && fetch_ack_i;
    fl  = (m_off == m_end);
    ll  = (m_lcnt == m_lw - 1);
    ld  = !m_act || (acc && fl);
    if (base_we_i) begin
      if (en_i || m_act) m_err = 1'b1;
      else begin m_base = base_wdata_i; m_err = 1'b0; end
    end
    if (!en_i) begin
      m_act = 0; m_off = '0; m_lcnt = '0; m_sof = 0;
    end else begin
      m_sof = !m_act || (acc && fl);
      m_act = 1;
      if (acc) begin
        m_off  = fl ? 17'd0 : m_off + 17'd4;
        m_lcnt = (fl || ll) ? 9'd0 : m_lcnt + 9'd1;
      end
    end
    if (ld) begin
      m_end = f_end(buf_size_i);
      m_lw  = f_lw(line_len_i, depth_i);
    end
  endtask

  // directed prefix: base write while idle, small frame with clamped line,
  // mid-frame config change (R8), blocked write (R9), disable (R10)
  task automatic drive(input int unsigned i);
    base_we_i = 1'b0;
    if (i < 4) begin
      en_i = 0; base_we_i = (i == 1); base_wdata_i = 4'h6;
      line_len_i = 7'd0; depth_i = 2'd0; buf_size_i = 10'd1; fetch_ack_i = 1;
    end else if (i < 80) begin
      en_i = 1; fetch_ack_i = 1;
      if (i == 10) begin line_len_i = 7'd100; depth_i = 2'd3; buf_size_i = 10'd2; end
      if (i == 20) begin base_we_i = 1; base_wdata_i = 4'h3; end
    end else if (i < 83) begin
      en_i = 0; fetch_ack_i = 1;   // R3: ack while idle ignored
    end else if (i < 90) begin
      en_i = 1; fetch_ack_i = 0;   // R3: no ack, offset holds
    end else begin
      if ($urandom_range(63) == 0) en_i = ~en_i;
      fetch_ack_i = ($urandom_range(3) != 0);
      base_we_i   = ($urandom_range(31) == 0);
      base_wdata_i = 4'($urandom_range(15));
      if ($urandom_range(15) == 0) begin
        line_len_i = 7'($urandom_range(127));
        depth_i    = 2'($urandom_range(3));
        buf_size_i = ($urandom_range(99) == 0) ? 10'd0 : 10'($urandom_range(1, 4));
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(base_o == 4'hC, "R1 base", 32'(base_o), 32'hC);
    chk(!fetch_req_o, "R1 req", 32'(fetch_req_o), 0);
    chk(!sof_o && !line_end_o, "R1 flags", 32'({sof_o, line_end_o}), 0);
    chk(!base_err_o, "R1 err", 32'(base_err_o), 0);
    m_act = 0; m_sof = 0; m_err = 0; m_off = '0; m_end = 17'h1FFFC;
    m_lcnt = '0; m_lw = 9'd2; m_base = 4'hC;
    rst_ni = 1'b1;
    for (int unsigned i = 0; i < NCYCLE; i++) begin
      drive(i);
      step_model();
      @(negedge clk_i);
      compare();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CYC * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule